// File: doc/BRIEF.md
# Timeslot Test Pattern Inserter

This block sits in a byte-wide time-division multiplexed stream. Each beat carries one data byte and the index of the timeslot it belongs to. Software chooses one timeslot index, from 0 to 65535. In that timeslot the block puts a test byte in place of the incoming byte. Every other timeslot passes through untouched. The test byte comes from one of two sources. The first is a pseudo-random generator built on an 11-bit shift register. The second is a fixed byte that software writes into a register. The same block fits on either side of a switch: in front of it to corrupt arriving traffic, or behind it to mark departing traffic.

Both stream sides use valid/ready. A beat moves when valid and ready are both high at a clock edge. The output side holds one registered beat. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is stalled, its data and index stay frozen. No beat is dropped or repeated. Configuration goes through a plain synchronous register port. It is written by the user but applied only when a beat with timeslot index 0 is accepted, so a frame never mixes two settings.

Top module: `ts_pattern_inserter`

## Requirements
- R1: After reset, `out_valid` is 0 and the target-slot, pattern and control registers all read 0, so substitution is disabled.
- R2: Register address 0 is the 16-bit target timeslot, address 1 the 8-bit pattern byte, and address 2 the control byte (bit 0 enable, bit 1 source: 0 pseudo-random, 1 fixed). Each reads back what was written, and control bits 7..2 read as 0.
- R3: A beat passes with its data unchanged when its index differs from the applied target or when substitution is disabled.
- R4: With fixed source selected, the beat in the target slot leaves carrying the pattern byte.
- R5: With pseudo-random source selected, the target beat carries the next 8 generator bits, first bit in bit 7. The bit sequence o obeys o[n+11] = o[n] XOR o[n+2], with o[0..10] all ones after reset, so the first byte after reset is 0xFF. The generator never holds all zeros.
- R6: The generator steps only when it supplies a byte. Its sequence runs on across frames and repeats every 2047 supplied bytes.
- R7: In pseudo-random mode the pattern register has no effect on the output.
- R8: A register write is applied when the next beat with index 0 is accepted, and that beat already uses it. Beats before that keep the earlier setting.
- R9: An accepted beat appears at the output on the next cycle, with its timeslot index unchanged.
- R10: `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds steady.
- R11: Target index 65535 is honoured like any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 8 | Input byte |
| in_ts | input | 16 | Timeslot index of the input beat |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream can accept the output beat |
| out_data | output | 8 | Output byte, possibly substituted |
| out_ts | output | 16 | Timeslot index of the output beat |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |

## Verification
The hardest case to reach from the ports is the wrap of the generator period. Hitting it takes 2047 substituted bytes, and each one needs a target-slot beat inside a frame. The stimulus therefore uses short four-slot frames for more than 2047 frames while the output is randomly back-pressured. The expected bytes come from the bench's own recurrence, read modulo 2047, so any error in stepping or in the period shows up. Separate phases write registers partway through a frame. They also target slot 65535, and they sweep every target over small eight-slot frames.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
  localparam int TS_W     = 16;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 2;
  localparam int LFSR_W   = 11;
  localparam int TAP_NEAR = 9;
  localparam int TAP_FAR  = 11;
  localparam int CTRL_EN  = 0;
  localparam int CTRL_FIX = 1;

  localparam logic [ADDR_W-1:0] A_SLOT = 2'd0;
  localparam logic [ADDR_W-1:0] A_PAT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  typedef struct packed {
    logic [TS_W-1:0]   slot;
    logic [DATA_W-1:0] pat;
    logic              en;
    logic              fixed;
  } tpi_cfg_t;
endpackage

// File: rtl/tpi_lfsr.sv
module tpi_lfsr #(
  parameter int W     = 11,
  parameter int NEAR  = 9,
  parameter int FAR   = 11,
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [STEPS-1:0] byte_o
);
  logic [W-1:0] state, nxt;

  // Fibonacci form: output is stage FAR, feedback of NEAR^FAR enters stage 1.
  always_comb begin
    logic [W-1:0] s;
    logic         fb;
    s = state;
    byte_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      byte_o[STEPS-1-i] = s[FAR-1];
      fb = s[NEAR-1] ^ s[FAR-1];
      s = {s[W-2:0], fb};
    end
    nxt = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            state <= '1;
    else if (state == '0)  state <= '1;
    else if (adv)          state <= (nxt == '0) ? '1 : nxt;
  end

  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state != '0);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/tpi_regs.sv
module tpi_regs
  import tpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              frame_load,
  output logic [REG_W-1:0]  rdata,
  output tpi_cfg_t          cfg_use
);
  tpi_cfg_t shadow, active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr_en) begin
        unique case (addr)
          A_SLOT: shadow.slot <= wdata[TS_W-1:0];
          A_PAT:  shadow.pat  <= wdata[DATA_W-1:0];
          A_CTRL: begin
            shadow.en    <= wdata[CTRL_EN];
            shadow.fixed <= wdata[CTRL_FIX];
          end
          default: ;
        endcase
      end
      if (frame_load) active <= shadow;
    end
  end

  // The beat that opens a frame already uses the pending settings.
  assign cfg_use = frame_load ? shadow : active;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_SLOT: rdata[TS_W-1:0]   = shadow.slot;
      A_PAT:  rdata[DATA_W-1:0] = shadow.pat;
      A_CTRL: begin
        rdata[CTRL_EN]  = shadow.en;
        rdata[CTRL_FIX] = shadow.fixed;
      end
      default: ;
    endcase
  end

  p_frame_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(active));
endmodule

// File: rtl/ts_pattern_inserter.sv
module ts_pattern_inserter
  import tpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TS_W-1:0]   in_ts,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TS_W-1:0]   out_ts,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  tpi_cfg_t          cfg;
  logic              fire, frame_load, hit, adv;
  logic [DATA_W-1:0] prbs_byte, sub_byte;

  assign in_ready   = !out_valid || out_ready;
  assign fire       = in_valid && in_ready;
  assign frame_load = fire && (in_ts == '0);

  tpi_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .frame_load (frame_load),
    .rdata      (reg_rdata),
    .cfg_use    (cfg)
  );

  assign hit      = fire && cfg.en && (in_ts == cfg.slot);
  assign adv      = hit && !cfg.fixed;
  assign sub_byte = cfg.fixed ? cfg.pat : prbs_byte;

  tpi_lfsr #(
    .W     (LFSR_W),
    .NEAR  (TAP_NEAR),
    .FAR   (TAP_FAR),
    .STEPS (DATA_W)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .byte_o (prbs_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ts    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= hit ? sub_byte : in_data;
      out_ts    <= in_ts;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ts));
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_ts == $past(in_ts));
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !(cfg.en && in_ts == cfg.slot) |=> out_data == $past(in_data));
endmodule

// File: tb/ts_pattern_inserter_bench.sv
module ts_pattern_inserter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1, reg_wr = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] in_ts = '0, reg_wdata = '0;
  logic [1:0]  reg_addr = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;
  logic [15:0] out_ts, reg_rdata;

  always #10 clk = ~clk;

  ts_pattern_inserter u_ts_pattern_inserter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ts(in_ts), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ts(out_ts), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  int errors = 0, checks = 0;
  string tag = "R3";
  logic bp_on = 1'b0;

  // Reference bit sequence: o[n] = o[n-11] ^ o[n-9], o[0..10] = 1
  logic seq [0:2057];
  int   prbs_k = 0;

  // Bench configuration model
  logic [15:0] sh_slot = 0, ac_slot = 0;
  logic [7:0]  sh_pat = 0, ac_pat = 0;
  logic        sh_en = 0, ac_en = 0, sh_fix = 0, ac_fix = 0;

  logic [7:0]  exp_d [0:16383];
  logic [15:0] exp_t [0:16383];
  int wp = 0, rp = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] prbs_byte(input int k);
    logic [7:0] v;
    int base;
    base = (k % 2047) * 8;
    for (int b = 0; b < 8; b++) v[7-b] = seq[(base + b) % 2047];
    return v;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    case (a)
      2'd0: sh_slot = d;
      2'd1: sh_pat = d[7:0];
      2'd2: begin sh_en = d[0]; sh_fix = d[1]; end
      default: ;
    endcase
  endtask

  task automatic reg_check(input string req, input logic [1:0] a, input logic [15:0] expv);
    @(negedge clk);
    reg_addr = a;
    #5 check(req, reg_rdata, expv);
  endtask

  task automatic send(input logic [15:0] ts, input logic [7:0] d);
    logic [7:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_ts = ts; in_data = d;
    #5;
    while (!in_ready) begin @(negedge clk); #5; end
    if (ts == 16'd0) begin
      ac_slot = sh_slot; ac_pat = sh_pat; ac_en = sh_en; ac_fix = sh_fix;
    end
    e = d;
    if (ac_en && ts == ac_slot) begin
      if (ac_fix) e = ac_pat;
      else begin e = prbs_byte(prbs_k); prbs_k++; end
    end
    exp_d[wp % 16384] = e; exp_t[wp % 16384] = ts; wp++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (rp != wp && guard < 200) begin @(negedge clk); guard++; end
    #6;
    check("R10 drain", rp, wp);
  endtask

  // Output monitor, sampled 5 ns after the falling edge
  logic        stalled = 1'b0;
  logic [7:0]  held_d;
  logic [15:0] held_t;
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      if (stalled) begin
        check("R10 hold valid", out_valid, 1'b1);
        check("R10 hold data", {out_data, out_ts}, {held_d, held_t});
      end
      check("R10 ready rule", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (rp == wp) check("R10 extra beat", 1, 0);
        else begin
          check({tag, " data"}, out_data, exp_d[rp % 16384]);
          check("R9 index", out_ts, exp_t[rp % 16384]);
          rp++;
        end
      end
      stalled = out_valid && !out_ready;
      held_d = out_data; held_t = out_ts;
    end
  end

  always @(negedge clk) out_ready <= bp_on ? ($urandom % 3 != 0) : 1'b1;

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 11; n++) seq[n] = 1'b1;
    for (int n = 11; n < 2058; n++) seq[n] = seq[n-11] ^ seq[n-9];

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #5 check("R1 out_valid", out_valid, 1'b0);
    reg_check("R1 slot", 2'd0, 16'h0);
    reg_check("R1 pattern", 2'd1, 16'h0);
    reg_check("R1 control", 2'd2, 16'h0);

    // R2 register readback and control padding
    reg_write(2'd0, 16'hABCD); reg_check("R2 slot", 2'd0, 16'hABCD);
    reg_write(2'd1, 16'h125A); reg_check("R2 pattern", 2'd1, 16'h005A);
    reg_write(2'd2, 16'h00FE); reg_check("R2 control", 2'd2, 16'h0002);
    reg_write(2'd2, 16'h0000); reg_check("R2 control clear", 2'd2, 16'h0000);

    // R3 disabled: everything passes
    tag = "R3";
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 6; s++) send(s[15:0], 8'(s * 31 + f));
    drain();

    // R8 settings wait for index 0; R4 fixed substitution
    reg_write(2'd0, 16'd3); reg_write(2'd1, 16'hA5); reg_write(2'd2, 16'h0003);
    tag = "R8";
    send(16'd3, 8'h11); send(16'd4, 8'h22);
    tag = "R4";
    for (int s = 0; s < 6; s++) send(s[15:0], 8'(s + 8'h40));
    tag = "R8";
    send(16'd0, 8'h50); send(16'd1, 8'h51);
    reg_write(2'd1, 16'h3C);
    send(16'd2, 8'h52); send(16'd3, 8'h53);
    for (int s = 0; s < 5; s++) send(s[15:0], 8'(s + 8'h60));
    drain();

    // R5/R7 pseudo-random with pattern register churn
    reg_write(2'd0, 16'd2); reg_write(2'd2, 16'h0001);
    tag = "R5";
    send(16'd0, 8'h00); send(16'd1, 8'h01); send(16'd2, 8'h02);
    drain();
    check("R5 first byte", exp_d[(rp - 1) % 16384], 8'hFF);
    tag = "R7";
    for (int f = 0; f < 30; f++) begin
      reg_write(2'd1, 16'(f * 37));
      for (int s = 0; s < 4; s++) send(s[15:0], 8'(f + s));
    end
    drain();

    // R6 period wrap under back-pressure
    tag = "R6";
    bp_on = 1'b1;
    for (int f = 0; f < 2100; f++)
      for (int s = 0; s < 4; s++) send(s[15:0], 8'(f ^ s));
    bp_on = 1'b0;
    drain();
    check("R6 bytes supplied", prbs_k > 2047 + 31, 1);

    // R11 top timeslot index
    reg_write(2'd0, 16'hFFFF); reg_write(2'd1, 16'h77); reg_write(2'd2, 16'h0003);
    tag = "R11";
    send(16'd0, 8'h01); send(16'hFFFE, 8'h02); send(16'hFFFF, 8'h03);
    send(16'd0, 8'h04); send(16'hFFFF, 8'h05);
    drain();

    // R9 one-cycle latency
    @(negedge clk); #5 check("R9 idle", out_valid, 1'b0);
    tag = "R9";
    send(16'd9, 8'h42);
    @(negedge clk); #5;
    check("R9 valid next cycle", out_valid, 1'b1);
    check("R9 index carried", out_ts, 16'd9);
    drain();

    // Sweep of every target over eight-slot frames, fixed source
    tag = "R4 sweep";
    bp_on = 1'b1;
    for (int t = 0; t < 8; t++) begin
      reg_write(2'd0, 16'(t)); reg_write(2'd1, 16'(8'hC0 + t));
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 8; s++) send(s[15:0], 8'(s * 17 + f));
    end
    bp_on = 1'b0;
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule